// File: doc/BRIEF.md
# Parked Data Bus Arbiter

This block hands out the data bus of a split-transaction processor bus to one of several masters. Master 0 is the processor and acts as the default owner. When the data bus is idle and nobody else asks for it, the grant rests on the processor. That grant does not wait for a transfer start, so a read tenure can open in the cycle right after the transfer start. This allows a burst of the 2-1-1-1 shape.

Each grant is registered. A grant only counts as qualified when the bus was not busy in the cycle before, so the arbiter clears every grant in the cycle after the busy signal is seen high. Other masters that raise a request are served in fixed priority order, with the lowest index first. The processor, signalled by its own request or by a transfer start, ranks above all of them.

In the fast-forwarding mode, the processor passes bus data to its execution units without a wait state. An address retry that arrives late would then corrupt that data. For this reason parking is only allowed in that mode when the system guarantees that read hits are never retried. The arbiter shows whether parking is currently in force on a status output.

Top module: `dbarb_parked`

## Requirements
- R1: While reset is asserted, every grant and the parking status are 0.
- R2: Parking is allowed in a cycle when no master demands the bus and `dbb_i` is low. If parking is allowed, `dbg_o` equals 1 (only bit 0 set) in the following cycle, whatever `ts_i` is.
- R3: If `dbb_i` is high in a cycle, every bit of `dbg_o` is 0 in the following cycle.
- R4: At most one bit of `dbg_o` is ever set.
- R5: If `dbb_i` is low, the demanding master with the lowest index receives the grant in the following cycle. Master 0 demands the bus when `req_i[0]` or `ts_i` is high; master i>0 demands it when `req_i[i]` is high.
- R6: Parking is allowed when `ff_mode_i` is 0 or `no_rd_retry_i` is 1. `park_en_o` shows whether parking was allowed in the previous cycle.
- R7: If parking is not allowed, no master demands the bus and `dbb_i` is low, every bit of `dbg_o` is 0 in the following cycle.
- R8: The first cycle after reset is released with an idle bus and parking allowed already carries the parked grant, and `park_en_o` is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Data bus request for each master |
| ts_i | input | 1 | Transfer start from the processor |
| dbb_i | input | 1 | Data bus busy |
| ff_mode_i | input | 1 | Processor fast-forwarding mode is active |
| no_rd_retry_i | input | 1 | System guarantees no address retry on read hits |
| dbg_o | output | N_MST | Qualified data bus grant for each master |
| park_en_o | output | 1 | Parking on the processor is in force |

## Verification
The hardest case to reach is the release of the busy signal. At that moment the grant has to move straight to the right owner: either a pending lower-priority master, or back to the parked processor. The parking policy may also have just changed in that same cycle. The stimulus holds `dbb_i` high for a few cycles while requests and the mode flags change underneath it. It then drops `dbb_i` with a chosen mix of requests and flags in place. Every cycle of the bus-busy window and every release are compared against the expected grant.

// File: rtl/dbarb_pkg.sv
package dbarb_pkg;
    // Index of the master the grant rests on when the bus is idle.
    localparam int unsigned DBARB_DEF_MST = 0;

    // Whether the processor may be parked under the current mode flags.
    function automatic logic dbarb_park_allowed(input logic ff_mode, input logic no_rd_retry);
        return (!ff_mode) || no_rd_retry;
    endfunction
endpackage

// File: rtl/dbarb_park_ctl.sv
module dbarb_park_ctl
    import dbarb_pkg::*;
(
    input  logic ff_mode_i,
    input  logic no_rd_retry_i,
    output logic park_ok_o
);
    // In fast-forward mode the processor has no spare cycle to notice a late
    // address retry, so the grant may only rest on it when read hits are
    // never retried.
    always_comb begin
        park_ok_o = dbarb_park_allowed(ff_mode_i, no_rd_retry_i);
    end
endmodule

// File: rtl/dbarb_prio.sv
module dbarb_prio #(
    parameter int unsigned N_MST = 4
) (
    input  logic [N_MST-1:0] dem_i,
    output logic [N_MST-1:0] win_o
);
    // seen[i] is set when any lower-index master demands the bus.
    logic [N_MST:0] seen;

    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N_MST; gi++) begin : g_chain
        assign seen[gi+1] = seen[gi] | dem_i[gi];
        assign win_o[gi]  = dem_i[gi] & ~seen[gi];
    end
endmodule

// File: rtl/dbarb_parked.sv
module dbarb_parked
    import dbarb_pkg::*;
#(
    parameter int unsigned N_MST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic             ts_i,
    input  logic             dbb_i,
    input  logic             ff_mode_i,
    input  logic             no_rd_retry_i,
    output logic [N_MST-1:0] dbg_o,
    output logic             park_en_o
);
    localparam logic [N_MST-1:0] DEF_ONEHOT = N_MST'(1) << DBARB_DEF_MST;

    typedef struct packed {
        logic             park;
        logic [N_MST-1:0] gnt;
    } arb_st_t;

    arb_st_t          st_d;
    arb_st_t          st_q;
    logic             park_ok;
    logic [N_MST-1:0] dem;
    logic [N_MST-1:0] win;

    dbarb_park_ctl u_park (
        .ff_mode_i     (ff_mode_i),
        .no_rd_retry_i (no_rd_retry_i),
        .park_ok_o     (park_ok)
    );

    // A transfer start from the processor counts as demand from it.
    always_comb begin
        dem = req_i;
        dem[DBARB_DEF_MST] = req_i[DBARB_DEF_MST] | ts_i;
    end

    dbarb_prio #(.N_MST(N_MST)) u_prio (
        .dem_i (dem),
        .win_o (win)
    );

    always_comb begin
        st_d      = st_q;
        st_d.park = park_ok;
        if (dbb_i) begin
            // A busy bus removes every qualified grant in the next cycle.
            st_d.gnt = '0;
        end else if (|dem) begin
            st_d.gnt = win;
        end else if (park_ok) begin
            st_d.gnt = DEF_ONEHOT;
        end else begin
            st_d.gnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbg_o     = st_q.gnt;
    assign park_en_o = st_q.park;
endmodule

// File: rtl/dbarb_parked_chk.sv
module dbarb_parked_chk #(
    parameter int unsigned N_MST = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] req_i,
    input logic             ts_i,
    input logic             dbb_i,
    input logic             ff_mode_i,
    input logic             no_rd_retry_i,
    input logic [N_MST-1:0] dbg_o,
    input logic             park_en_o
);
    logic allow;
    logic any_dem;
    assign allow   = !ff_mode_i || no_rd_retry_i;
    assign any_dem = (|req_i) || ts_i;

    p_idle_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbb_i && !any_dem && allow) |=> (dbg_o == N_MST'(1)));

    p_busy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dbb_i |=> (dbg_o == '0));

    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dbg_o));

    p_proc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbb_i && (req_i[0] || ts_i)) |=> dbg_o[0]);

    p_park_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        allow |=> park_en_o);

    p_park_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |=> !park_en_o);

    p_no_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbb_i && !any_dem && !allow) |=> (dbg_o == '0));
endmodule

bind dbarb_parked dbarb_parked_chk #(.N_MST(N_MST)) u_chk (.*);

// File: tb/dbarb_parked_test.sv
`timescale 1ns/1ps
module dbarb_parked_test;
    localparam int N = 4;

    typedef struct {
        logic [N-1:0] gnt;
        logic         park;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         ts = 1'b0;
    logic         dbb = 1'b0;
    logic         ff = 1'b0;
    logic         nr = 1'b0;
    logic [N-1:0] dbg;
    logic         park_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    dbarb_parked #(.N_MST(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ts_i(ts), .dbb_i(dbb),
        .ff_mode_i(ff), .no_rd_retry_i(nr), .dbg_o(dbg), .park_en_o(park_en)
    );

    function automatic exp_t model(logic [N-1:0] r, logic t, logic b, logic f, logic n, string tag);
        exp_t e;
        logic [N-1:0] d;
        e.tag  = tag;
        e.park = !f || n;
        e.gnt  = '0;
        d = r;
        d[0] = r[0] | t;
        if (!b) begin
            if (d != '0) begin
                for (int i = N - 1; i >= 0; i--) if (d[i]) e.gnt = N'(1) << i;
            end else if (e.park) begin
                e.gnt = N'(1);
            end
        end
        return e;
    endfunction

    task automatic step(logic [N-1:0] r, logic t, logic b, logic f, logic n, string tag);
        @(negedge clk);
        req = r; ts = t; dbb = b; ff = f; nr = n;
        q.push_back(model(r, t, b, f, n, tag));
    endtask

    task automatic check(string tag, logic [N:0] act, logic [N:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {park_en, dbg}, {e.park, e.gnt});
                checks++;
                if ($countones(dbg) > 1) begin
                    errors++;
                    $display("FAIL R4 actual=%b expected=at most one bit", dbg);
                end
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {park_en, dbg}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: the first cycle out of reset is already parked
        q.push_back(model('0, 0, 0, 0, 0, "R8 first cycle parked"));
        // R2: parked grant, with and without a transfer start
        step('0, 0, 0, 0, 0, "R2 idle parked");
        step('0, 1, 0, 0, 0, "R2 parked with ts");
        step('0, 0, 0, 0, 0, "R2 parked again");
        // R3: busy bus clears every grant, then the grant returns to master 0
        step('0, 0, 1, 0, 0, "R3 busy drop");
        step(4'b0100, 0, 1, 0, 0, "R3 busy with request");
        step('0, 0, 0, 0, 0, "R2 return to default");
        // R5: fixed priority among demanding masters
        step(4'b0110, 0, 0, 0, 0, "R5 master1 over master2");
        step(4'b1000, 0, 0, 0, 0, "R5 master3 alone");
        step(4'b0101, 0, 0, 0, 0, "R5 master0 first");
        step(4'b1000, 1, 0, 0, 0, "R5 ts beats master3");
        step(4'b1100, 0, 1, 0, 0, "R3 busy with two requests");
        step(4'b1100, 0, 0, 0, 0, "R5 release to master2");
        // R6/R7: fast-forward mode without the no-retry guarantee
        step('0, 0, 0, 1, 0, "R7 parking off");
        step('0, 0, 0, 1, 0, "R7 stays unparked");
        step('0, 1, 0, 1, 0, "R7 ts grants master0");
        step(4'b0100, 0, 0, 1, 0, "R7 request grants master2");
        step('0, 0, 0, 1, 1, "R6 guarantee restores parking");
        step('0, 0, 1, 1, 0, "R6 flag change under busy");
        step('0, 0, 0, 1, 0, "R7 release without parking");
        step('0, 0, 0, 0, 0, "R6 mode off parks");
        step('0, 0, 1, 0, 1, "R3 busy parked policy");
        step('0, 0, 0, 0, 1, "R2 release parks");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule